// File: doc/BRIEF.md
# Prescaled Free-Running Timer

A general-purpose timer with a 32-bit up-counter behind a small word-addressed register bus. The counter advances on ticks from one of two sources. The first is the block's own clock, taken on every cycle. The second is a slow reference that arrives as a one-cycle pulse on `osc_tick_i`. The reference path passes through its own 4-bit divider and then through the shared 12-bit divider. The peripheral-clock path uses only the shared divider.

Three compare registers watch the count. Each match sets a sticky status flag. Software clears a flag by writing 1 to it. An interrupt line combines the flags with per-flag enable bits.

The counter has two modes:
- In free-running mode it wraps at the top of its range.
- Otherwise, a match on the first compare register restarts it from zero.

A self-clearing software reset sets every register and every divider back to zero. It holds the reset bit high for a fixed number of cycles so that software can poll it.

Top module: `gp_tick_timer`

## Requirements
- R1: After the asynchronous reset every register reads 0 and `irq_o` is 0.
- R2: Word addresses are 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 0/1/2, 7/8 capture (read 0, writes ignored), 9 counter (writable), 10 to 15 read 0. Read data follows `addr_i` combinationally. A write takes effect when `req_i` and `we_i` are both high. Control keeps only bit 0 (enable), bits 8:6 (source), bit 9 (free-run) and bit 10 (reference enable); its other bits read 0. Prescaler keeps bits 15:0, interrupt enable keeps bits 2:0, and status keeps bits 2:0.
- R3: With source 1 and enable set, the counter increments once per (P+1) clock cycles, where P is prescaler bits 11:0.
- R4: With source 5, bit 10 and enable all set, the counter increments once per (Q+1)·(P+1) reference pulses, where Q is prescaler bits 15:12. If bit 10 is clear, reference pulses do not advance the counter.
- R5: A source value other than 1 or 5 produces no counter ticks.
- R6: In free-running mode a tick at 0xFFFFFFFF gives 0, and a match on compare 0 does not restart the count.
- R7: With free-running mode clear, a tick while the count equals compare 0 loads 0 instead of count+1.
- R8: A tick while the count equals compare k sets status bit k. Writing 1 to a status bit clears it. If a set and a clear arrive on the same cycle, the set wins.
- R9: `irq_o` is high exactly when some status bit and its interrupt-enable bit are both 1.
- R10: Clearing the enable bit freezes both the counter and the divider state. Setting it again resumes the count from where it stopped.
- R11: Writing 1 to control bit 15 clears every register and divider on that edge. Bit 15 then reads 1 for 4 cycles and 0 afterwards. Bus writes during those 4 cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock, also the source-1 tick |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word |
| osc_tick_i | input | 1 | One-cycle pulse from the slow reference |
| irq_o | output | 1 | Enabled compare-flag interrupt |

## Verification
A behavioural model in the bench follows the block cycle by cycle. The read data and the interrupt line are compared with it on every clock.

The peripheral source runs with a divide-by-3 prescaler, and the enable is toggled mid-period; this separates a divider that holds its phase from one that restarts. Reference pulses arrive every third cycle through both dividers, once with the reference enable set and once with it clear; this shows whether the two dividers are cascaded and whether the gate is applied. An unused source code, a counter preloaded just below the top of its range, and a short reload period separate the free-running path from the compare-restart path. Flag clears written on every cycle, against a match that recurs every four cycles, show whether set takes priority over clear.

// File: rtl/gp_tick_timer_pkg.sv
package gp_tick_timer_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned N_CMP  = 3;

  localparam logic [REG_AW-1:0] RA_CTRL = 4'd0;
  localparam logic [REG_AW-1:0] RA_PSC  = 4'd1;
  localparam logic [REG_AW-1:0] RA_STAT = 4'd2;
  localparam logic [REG_AW-1:0] RA_IEN  = 4'd3;
  localparam logic [REG_AW-1:0] RA_CMP0 = 4'd4;
  localparam logic [REG_AW-1:0] RA_CNT  = 4'd9;

  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_SRC_LO = 6;
  localparam int unsigned SRC_W     = 3;
  localparam int unsigned CB_FRR    = 9;
  localparam int unsigned CB_OSC    = 10;
  localparam int unsigned CB_SRST   = 15;

  localparam logic [SRC_W-1:0] SRC_PERIPH = 3'd1;
  localparam logic [SRC_W-1:0] SRC_OSC    = 3'd5;

  typedef struct packed {
    logic             osc_en;
    logic             frr;
    logic [SRC_W-1:0] src;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/gtt_divider.sv
module gtt_divider #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         in_i,
  input  logic [W-1:0] lim_i,
  output logic         out_o
);
  logic [W-1:0] cnt_q;
  logic         hit;

  assign hit   = (cnt_q == lim_i);
  assign out_o = en_i & in_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (en_i && in_i)  cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  // R3: a terminal input pulse restarts the phase
  a_r3_div_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && in_i && hit && !clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/gtt_prescale.sv
module gtt_prescale
  import gp_tick_timer_pkg::*;
#(
  parameter int unsigned MAIN_W = 12,
  parameter int unsigned OSC_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              osc_en_i,
  input  logic              osc_tick_i,
  input  logic [OSC_W-1:0]  osc_div_i,
  input  logic [MAIN_W-1:0] main_div_i,
  output logic              tick_o
);
  logic osc_sel, periph_sel, osc_stage;

  assign osc_sel    = (src_i == SRC_OSC) & osc_en_i;
  assign periph_sel = (src_i == SRC_PERIPH);

  gtt_divider #(.W(OSC_W)) u_osc_div (
    .clk_i, .rst_ni, .clr_i, .en_i,
    .in_i  (osc_sel & osc_tick_i),
    .lim_i (osc_div_i),
    .out_o (osc_stage)
  );

  gtt_divider #(.W(MAIN_W)) u_main_div (
    .clk_i, .rst_ni, .clr_i, .en_i,
    .in_i  (periph_sel | osc_stage),
    .lim_i (main_div_i),
    .out_o (tick_o)
  );

  // R5: no tick for an unused source code
  a_r5_src_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(src_i == SRC_PERIPH || src_i == SRC_OSC) |-> !tick_o);
  // R10: no tick while disabled
  a_r10_no_tick_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);
endmodule

// File: rtl/gtt_counter.sv
module gtt_counter #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                en_i,
  input  logic                tick_i,
  input  logic                frr_i,
  input  logic                ld_i,
  input  logic [W-1:0]        ld_val_i,
  input  logic [N-1:0][W-1:0] cmp_i,
  output logic [W-1:0]        cnt_o,
  output logic [N-1:0]        match_o
);
  logic [W-1:0] cnt_q;

  for (genvar k = 0; k < N; k++) begin : g_match
    assign match_o[k] = tick_i & (cnt_q == cmp_i[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (ld_i)    cnt_q <= ld_val_i;
    else if (tick_i)  cnt_q <= (!frr_i && cnt_q == cmp_i[0]) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && frr_i && cnt_q == '1 && !ld_i && !clr_i) |=> (cnt_q == '0));
  a_r7_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !frr_i && cnt_q == cmp_i[0] && !ld_i && !clr_i) |=> (cnt_q == '0));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ld_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/gtt_flags.sv
module gtt_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] match_i,
  input  logic [N-1:0] w1c_i,
  input  logic [N-1:0] ien_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] status_q;

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          status_q[k] <= 1'b0;
      else if (clr_i)       status_q[k] <= 1'b0;
      else if (match_i[k])  status_q[k] <= 1'b1;
      else if (w1c_i[k])    status_q[k] <= 1'b0;
    end

    // R8: set wins over a same-cycle clear
    a_r8_set_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match_i[k] && !clr_i) |=> status_q[k]);
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & ien_i);
endmodule

// File: rtl/gp_tick_timer.sv
module gp_tick_timer
  import gp_tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned MAIN_PS_W   = 12,
  parameter int unsigned OSC_PS_W    = 4,
  parameter int unsigned SRST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              osc_tick_i,
  output logic              irq_o
);
  localparam int unsigned SRST_CW = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;

  ctrl_t                       ctrl_q;
  logic [MAIN_PS_W-1:0]        psc_main_q;
  logic [OSC_PS_W-1:0]         psc_osc_q;
  logic [N_CMP-1:0]            ien_q;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_q;
  logic                        busy_q;
  logic [SRST_CW-1:0]          srst_cnt_q;

  logic                        wr_en, srst_go, clr, cnt_tick;
  logic [N_CMP-1:0]            match_w, status_w, w1c;
  logic [CNT_W-1:0]            cnt_w;

  assign wr_en   = req_i & we_i & ~busy_q;
  assign srst_go = wr_en & (addr_i == RA_CTRL) & wdata_i[CB_SRST];
  assign clr     = busy_q | srst_go;
  assign w1c     = (wr_en && addr_i == RA_STAT) ? wdata_i[N_CMP-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      psc_main_q <= '0;
      psc_osc_q  <= '0;
      ien_q      <= '0;
    end else if (clr) begin
      ctrl_q     <= '0;
      psc_main_q <= '0;
      psc_osc_q  <= '0;
      ien_q      <= '0;
    end else if (wr_en) begin
      case (addr_i)
        RA_CTRL: begin
          ctrl_q.en     <= wdata_i[CB_EN];
          ctrl_q.src    <= wdata_i[CB_SRC_LO +: SRC_W];
          ctrl_q.frr    <= wdata_i[CB_FRR];
          ctrl_q.osc_en <= wdata_i[CB_OSC];
        end
        RA_PSC: begin
          psc_main_q <= wdata_i[MAIN_PS_W-1:0];
          psc_osc_q  <= wdata_i[MAIN_PS_W +: OSC_PS_W];
        end
        RA_IEN:  ien_q <= wdata_i[N_CMP-1:0];
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cmp_q[k] <= '0;
      else if (clr)   cmp_q[k] <= '0;
      else if (wr_en && addr_i == RA_CMP0 + REG_AW'(k))
                      cmp_q[k] <= wdata_i[CNT_W-1:0];
    end
  end

  // self-clearing reset sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      srst_cnt_q <= '0;
    end else if (srst_go) begin
      busy_q     <= 1'b1;
      srst_cnt_q <= SRST_CW'(SRST_CYCLES - 1);
    end else if (busy_q) begin
      if (srst_cnt_q == '0) busy_q <= 1'b0;
      else                  srst_cnt_q <= srst_cnt_q - 1'b1;
    end
  end

  gtt_prescale #(.MAIN_W(MAIN_PS_W), .OSC_W(OSC_PS_W)) u_psc (
    .clk_i, .rst_ni,
    .clr_i      (clr),
    .en_i       (ctrl_q.en),
    .src_i      (ctrl_q.src),
    .osc_en_i   (ctrl_q.osc_en),
    .osc_tick_i,
    .osc_div_i  (psc_osc_q),
    .main_div_i (psc_main_q),
    .tick_o     (cnt_tick)
  );

  gtt_counter #(.W(CNT_W), .N(N_CMP)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i    (clr),
    .en_i     (ctrl_q.en),
    .tick_i   (cnt_tick),
    .frr_i    (ctrl_q.frr),
    .ld_i     (wr_en && addr_i == RA_CNT),
    .ld_val_i (wdata_i[CNT_W-1:0]),
    .cmp_i    (cmp_q),
    .cnt_o    (cnt_w),
    .match_o  (match_w)
  );

  gtt_flags #(.N(N_CMP)) u_flg (
    .clk_i, .rst_ni,
    .clr_i    (clr),
    .match_i  (match_w),
    .w1c_i    (w1c),
    .ien_i    (ien_q),
    .status_o (status_w),
    .irq_o
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL: begin
        rdata_o[CB_EN]              = ctrl_q.en;
        rdata_o[CB_SRC_LO +: SRC_W] = ctrl_q.src;
        rdata_o[CB_FRR]             = ctrl_q.frr;
        rdata_o[CB_OSC]             = ctrl_q.osc_en;
        rdata_o[CB_SRST]            = busy_q;
      end
      RA_PSC: begin
        rdata_o[MAIN_PS_W-1:0]         = psc_main_q;
        rdata_o[MAIN_PS_W +: OSC_PS_W] = psc_osc_q;
      end
      RA_STAT: rdata_o[N_CMP-1:0] = status_w;
      RA_IEN:  rdata_o[N_CMP-1:0] = ien_q;
      RA_CNT:  rdata_o[CNT_W-1:0] = cnt_w;
      default: ;
    endcase
    for (int k = 0; k < N_CMP; k++)
      if (addr_i == RA_CMP0 + REG_AW'(k)) rdata_o[CNT_W-1:0] = cmp_q[k];
  end

  a_r11_cleared_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_w == '0 && status_w == '0 && !irq_o));
  a_r11_ctrl_zero_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (ctrl_q == '0 && ien_q == '0));
endmodule

// File: tb/gp_tick_timer_test.sv
module gp_tick_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, osc = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  bit          m_en, m_frr, m_oe, m_busy;
  int          m_src, m_mps, m_ops, m_ier, m_st, m_pa, m_pb, m_bcnt;
  logic [31:0] m_cmp [3];
  logic [31:0] m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  gp_tick_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .osc_tick_i(osc), .irq_o(irq)
  );

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    logic [31:0] v = '0;
    case (a)
      4'd0: begin v[0] = m_en; v[8:6] = m_src[2:0]; v[9] = m_frr; v[10] = m_oe; v[15] = m_busy; end
      4'd1: v = 32'(m_ops * 4096 + m_mps);
      4'd2: v = 32'(m_st);
      4'd3: v = 32'(m_ier);
      4'd4, 4'd5, 4'd6: v = m_cmp[a - 4];
      4'd9: v = m_cnt;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_clear();
    m_en = 0; m_frr = 0; m_oe = 0; m_src = 0; m_mps = 0; m_ops = 0; m_ier = 0;
    m_st = 0; m_pa = 0; m_pb = 0; m_cnt = '0;
    for (int k = 0; k < 3; k++) m_cmp[k] = '0;
  endtask

  task automatic model_update(input bit wr, input logic [3:0] a, input logic [31:0] d, input bit o);
    bit go, clr, w, oin, oout, min, tick;
    bit [2:0] mt;
    go   = wr && a == 4'd0 && d[15] && !m_busy;
    clr  = m_busy || go;
    w    = wr && !m_busy;
    oin  = (m_src == 5) && m_oe && o;
    oout = m_en && oin && (m_pb == m_ops);
    min  = (m_src == 1) || oout;
    tick = m_en && min && (m_pa == m_mps);
    for (int k = 0; k < 3; k++) mt[k] = tick && (m_cnt == m_cmp[k]);
    if (clr) model_clear();
    else begin
      if (m_en && oin) m_pb = (m_pb == m_ops) ? 0 : (m_pb + 1) % 16;
      if (m_en && min) m_pa = (m_pa == m_mps) ? 0 : (m_pa + 1) % 4096;
      if (w && a == 4'd9) m_cnt = d;
      else if (tick) m_cnt = (!m_frr && m_cnt == m_cmp[0]) ? 32'd0 : m_cnt + 32'd1;
      for (int k = 0; k < 3; k++) begin
        if (mt[k]) m_st = m_st | (1 << k);
        else if (w && a == 4'd2 && d[k]) m_st = m_st & ~(1 << k);
      end
      if (w) case (a)
        4'd0: begin m_en = d[0]; m_src = int'(d[8:6]); m_frr = d[9]; m_oe = d[10]; end
        4'd1: begin m_mps = int'(d[11:0]); m_ops = int'(d[15:12]); end
        4'd3: m_ier = int'(d[2:0]);
        4'd4, 4'd5, 4'd6: m_cmp[a - 4] = d;
        default: ;
      endcase
    end
    if (go) begin m_busy = 1; m_bcnt = 3; end
    else if (m_busy) begin
      if (m_bcnt == 0) m_busy = 0; else m_bcnt--;
    end
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit w, input logic [3:0] a, input logic [31:0] d,
                      input bit o, input string tag);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; osc = o;
    #1;
    check(tag, $sformatf("rdata@%0d", a), rdata, exp_rd(a));
    check(tag, "irq", {31'b0, irq}, {31'b0, (m_st & m_ier) != 0});
    @(posedge clk);
    model_update(r && w, a, d, o);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(1, 0, a, '0, 0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    step(1, 1, a, d, 0, tag);
  endtask

  task automatic soft_reset(input string tag);
    wr(4'd0, 32'h8000, tag);
    repeat (4) rd(4'd0, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    model_clear();
    m_busy = 0; m_bcnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int a = 0; a < 16; a++) rd(4'(a), "R1");

    // R2: register map and field masks
    wr(4'd0, 32'hFFFF_7FFF, "R2"); rd(4'd0, "R2");
    wr(4'd1, 32'hFFFF_FFFF, "R2"); rd(4'd1, "R2");
    wr(4'd3, 32'h0000_00FF, "R2"); rd(4'd3, "R2");
    wr(4'd4, 32'h1111_1111, "R2"); wr(4'd5, 32'h2222_2222, "R2"); wr(4'd6, 32'h3333_3333, "R2");
    rd(4'd4, "R2"); rd(4'd5, "R2"); rd(4'd6, "R2");
    wr(4'd7, 32'hDEAD_BEEF, "R2"); wr(4'd8, 32'hCAFE_F00D, "R2"); wr(4'd12, 32'h5A5A_5A5A, "R2");
    rd(4'd7, "R2"); rd(4'd8, "R2"); rd(4'd12, "R2");
    repeat (4) rd(4'd9, "R5");

    // R11: self-clearing reset, writes ignored while busy
    wr(4'd0, 32'h8000, "R11");
    wr(4'd3, 32'h7, "R11");
    repeat (5) rd(4'd0, "R11");
    rd(4'd3, "R11"); rd(4'd4, "R11"); rd(4'd1, "R11");

    // R3: peripheral clock, divide by 3
    wr(4'd1, 32'd2, "R3");
    wr(4'd0, 32'h241, "R3");
    repeat (14) rd(4'd9, "R3");

    // R10: freeze and resume mid-period
    wr(4'd0, 32'h240, "R10");
    repeat (5) rd(4'd9, "R10");
    wr(4'd0, 32'h241, "R10");
    repeat (7) rd(4'd9, "R10");

    // R4: reference path, cascaded dividers
    soft_reset("R4");
    wr(4'd1, 32'h2001, "R4");
    wr(4'd0, 32'h741, "R4");
    for (int i = 0; i < 60; i++) step(1, 0, 4'd9, '0, (i % 3) == 0, "R4");
    wr(4'd0, 32'h341, "R4");
    for (int i = 0; i < 24; i++) step(1, 0, 4'd9, '0, (i % 3) == 0, "R4");

    // R5: unused source code
    wr(4'd0, 32'h2C1, "R5");
    repeat (8) rd(4'd9, "R5");

    // R6: free-running wrap, no restart on compare 0
    wr(4'd1, 32'd0, "R6");
    wr(4'd4, 32'hFFFF_FFFE, "R6");
    wr(4'd9, 32'hFFFF_FFFC, "R6");
    wr(4'd0, 32'h241, "R6");
    repeat (8) rd(4'd9, "R6");

    // R7: compare-0 restart
    wr(4'd0, 32'h0, "R7");
    wr(4'd9, 32'd0, "R7");
    wr(4'd4, 32'd5, "R7");
    wr(4'd0, 32'h41, "R7");
    repeat (16) rd(4'd9, "R7");

    // R8 / R9: flags, clear, interrupt gating
    soft_reset("R8");
    wr(4'd4, 32'd100, "R8"); wr(4'd5, 32'd3, "R8"); wr(4'd6, 32'd4, "R8");
    wr(4'd0, 32'h241, "R8");
    repeat (8) rd(4'd2, "R8");
    wr(4'd2, 32'h2, "R8"); rd(4'd2, "R8");
    wr(4'd3, 32'h5, "R9"); rd(4'd2, "R9");
    wr(4'd3, 32'h4, "R9"); rd(4'd2, "R9");
    wr(4'd2, 32'h4, "R9"); rd(4'd2, "R9");
    wr(4'd3, 32'h2, "R9"); rd(4'd2, "R9");

    // R8: set beats same-cycle clear; restart period 4 with match on count 1
    wr(4'd0, 32'h0, "R8");
    wr(4'd9, 32'd0, "R8");
    wr(4'd4, 32'd3, "R8"); wr(4'd5, 32'd1, "R8");
    wr(4'd0, 32'h41, "R8");
    repeat (12) wr(4'd2, 32'h2, "R8");
    rd(4'd2, "R8");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule